// File: doc/BRIEF.md
# Amplifier Enable and Settle Sequencer

This block is the digital control for a group of up to three analog amplifier instances. It decides when each instance is powered and when its output driver is on. It also tells the rest of the chip when each instance's output has had time to settle. The analog amplifiers and resistor networks sit outside the block. Only their power and driver controls leave it, as `amp_on` and `drive_en`.

A shared divider turns the peripheral clock into one-microsecond ticks. The count per tick comes from a timebase value: the number of peripheral clocks needed to span at least one microsecond, minus one. Each instance has its own 7-bit settle time in microseconds. When an instance switches on, it loads that value and counts it down on the ticks. At the end of the count it raises a settled flag and gives a one-cycle ready pulse.

An instance is switched on either by its always-on bit or by enable and disable event pulses. In the driver's off mode, a drive event level turns the driver on. In normal mode the driver is on for as long as the instance is on. All configuration values are plain inputs, held steady by a register bank outside the block, and all outputs are plain control levels or pulses.

Top module: `amp_settle_seq`

## Requirements
- R1: With `periph_en` low, the tick divider is held at zero. Once `periph_en` is high, a tick occurs every `timebase`+1 cycles. An instance whose `always_on` bit is set when `periph_en` rises starts on that first edge. With settle time S≥1, its `settled` output rises after exactly S·(`timebase`+1) rising edges when `timebase`≥1, and after S+1 edges when `timebase` is 0. The first edge is counted as 1.
- R2: Each instance's 7-bit settle field (bits [7i+6:7i] of `settle_time`, maximum 0x7F) sets how many ticks pass between start and settled. A field of 0 gives settled on the start edge itself.
- R3: When the countdown expires, `settled` rises and `ready_ev` is high for exactly that one cycle.
- R4: An instance is on (`amp_on`=1) when `periph_en` is high and either its `always_on` bit or its event-driven state is set.
- R5: Enable and disable events change the event-driven state only while `always_on` is 0 and `event_en` is 1. Otherwise they are ignored.
- R6: An enable and a disable event in the same cycle act as a disable.
- R7: When an instance turns off, `settled` drops in the same cycle. Turning it on again reloads the settle time and runs the full countdown again.
- R8: `drive_en` is 0 whenever the instance is off. When the instance is on, `drive_en` is 1 in normal mode (`out_normal`=1). In off mode (`out_normal`=0) it follows the `ev_drive` level.
- R9: While `periph_en` is low, every instance is off and the event-driven state of each is cleared, so raising `periph_en` again does not bring back an instance that events had switched on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_en | input | 1 | Global enable for the whole block |
| timebase | input | 8 | Clocks per microsecond tick, minus one |
| settle_time | input | 21 | Packed 7-bit settle times, instance i at [7i+6:7i] |
| always_on | input | 3 | Per-instance always-on bit |
| event_en | input | 3 | Per-instance event-enable bit |
| out_normal | input | 3 | Per-instance output mode: 1 normal, 0 off |
| ev_enable | input | 3 | Enable event pulse per instance |
| ev_disable | input | 3 | Disable event pulse per instance |
| ev_drive | input | 3 | Drive event level per instance |
| amp_on | output | 3 | Amplifier power control per instance |
| drive_en | output | 3 | Output driver enable per instance |
| settled | output | 3 | Settled status flag per instance |
| ready_ev | output | 3 | One-cycle ready event per instance |

## Verification
Two cases can land in the same cycle. The first is an enable event arriving together with a disable event. The bench drives both pulses on one edge, once from the on state and once from the off state, and expects `amp_on` low afterwards in both cases. The second is an instance start falling on an edge that is also a microsecond tick. The bench forces this with a timebase of zero, where every edge is a tick. It then expects the start edge not to count as a tick, which gives S+1 edges instead of S·(timebase+1).

// File: rtl/amp_seq_pkg.sv
`timescale 1ns/1ps
package amp_seq_pkg;
  typedef enum logic {
    DRV_OFF    = 1'b0,
    DRV_NORMAL = 1'b1
  } drv_mode_e;

  localparam int unsigned SETTLE_MAX = 127;
endpackage

// File: rtl/us_tick_gen.sv
`timescale 1ns/1ps
module us_tick_gen #(
  parameter int unsigned TB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [TB_W-1:0] timebase,
  output logic            tick
);
  logic [TB_W-1:0] cnt_q;

  assign tick = en && (cnt_q >= timebase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/amp_power_ctl.sv
`timescale 1ns/1ps
module amp_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic periph_en,
  input  logic always_on,
  input  logic event_en,
  input  logic ev_enable,
  input  logic ev_disable,
  output logic amp_on,
  output logic start
);
  logic ev_state_q;
  logic on_d_q;
  logic ev_live;

  assign ev_live = !always_on && event_en;
  assign amp_on  = periph_en && (always_on || ev_state_q);
  assign start   = amp_on && !on_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_state_q <= 1'b0;
      on_d_q     <= 1'b0;
    end else begin
      on_d_q <= amp_on;
      if (!periph_en) begin
        ev_state_q <= 1'b0;
      end else if (ev_live) begin
        if (ev_disable) begin
          ev_state_q <= 1'b0;
        end else if (ev_enable) begin
          ev_state_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/settle_timer.sv
`timescale 1ns/1ps
module settle_timer #(
  parameter int unsigned SW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on,
  input  logic          start,
  input  logic          tick,
  input  logic [SW-1:0] settle_len,
  output logic          settled,
  output logic          ready
);
  logic [SW-1:0] remain_q;
  logic          run_q;
  logic          done_q;
  logic          rdy_q;
  logic          zero_len;

  assign zero_len = (settle_len == '0);
  assign settled  = done_q && on;
  assign ready    = rdy_q && on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      rdy_q    <= 1'b0;
    end else if (!on) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else if (start) begin
      remain_q <= settle_len;
      run_q    <= !zero_len;
      done_q   <= zero_len;
      rdy_q    <= zero_len;
    end else begin
      rdy_q <= 1'b0;
      if (run_q && tick) begin
        if (remain_q <= 1) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          rdy_q  <= 1'b1;
        end else begin
          remain_q <= remain_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/amp_settle_seq.sv
`timescale 1ns/1ps
module amp_settle_seq
  import amp_seq_pkg::*;
#(
  parameter int unsigned N    = 3,
  parameter int unsigned TB_W = 8,
  parameter int unsigned SW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            periph_en,
  input  logic [TB_W-1:0] timebase,
  input  logic [N*SW-1:0] settle_time,
  input  logic [N-1:0]    always_on,
  input  logic [N-1:0]    event_en,
  input  logic [N-1:0]    out_normal,
  input  logic [N-1:0]    ev_enable,
  input  logic [N-1:0]    ev_disable,
  input  logic [N-1:0]    ev_drive,
  output logic [N-1:0]    amp_on,
  output logic [N-1:0]    drive_en,
  output logic [N-1:0]    settled,
  output logic [N-1:0]    ready_ev
);
  logic us_tick;

  us_tick_gen #(.TB_W(TB_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (periph_en),
    .timebase (timebase),
    .tick     (us_tick)
  );

  for (genvar i = 0; i < N; i++) begin : g_amp
    logic      start_i;
    drv_mode_e mode_i;

    assign mode_i = drv_mode_e'(out_normal[i]);

    amp_power_ctl u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .periph_en  (periph_en),
      .always_on  (always_on[i]),
      .event_en   (event_en[i]),
      .ev_enable  (ev_enable[i]),
      .ev_disable (ev_disable[i]),
      .amp_on     (amp_on[i]),
      .start      (start_i)
    );

    settle_timer #(.SW(SW)) u_settle (
      .clk        (clk),
      .rst_n      (rst_n),
      .on         (amp_on[i]),
      .start      (start_i),
      .tick       (us_tick),
      .settle_len (settle_time[i*SW +: SW]),
      .settled    (settled[i]),
      .ready      (ready_ev[i])
    );

    always_comb begin
      drive_en[i] = 1'b0;
      if (amp_on[i]) begin
        drive_en[i] = (mode_i == DRV_NORMAL) || ev_drive[i];
      end
    end
  end
endmodule

// File: rtl/amp_settle_seq_chk.sv
`timescale 1ns/1ps
module amp_settle_seq_chk #(
  parameter int unsigned N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         periph_en,
  input logic [N-1:0] amp_on,
  input logic [N-1:0] drive_en,
  input logic [N-1:0] settled,
  input logic [N-1:0] ready_ev
);
  // R9
  periph_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |-> (amp_on == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3
    ready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_ev[i] |-> settled[i]);
    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_ev[i] |=> !ready_ev[i]);
    // R3
    settle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled[i]) |-> ready_ev[i]);
    // R7
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !amp_on[i] |-> !settled[i]);
    // R8
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en[i] |-> amp_on[i]);
  end
endmodule

bind amp_settle_seq amp_settle_seq_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .periph_en (periph_en),
  .amp_on    (amp_on),
  .drive_en  (drive_en),
  .settled   (settled),
  .ready_ev  (ready_ev)
);

// File: tb/amp_settle_seq_test.sv
`timescale 1ns/1ps
module amp_settle_seq_test;
  localparam int N = 3;
  localparam int SW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          periph_en = 1'b0;
  logic [7:0]    timebase = '0;
  logic [N*SW-1:0] settle_time = '0;
  logic [N-1:0]  always_on = '0;
  logic [N-1:0]  event_en = '0;
  logic [N-1:0]  out_normal = '0;
  logic [N-1:0]  ev_enable = '0;
  logic [N-1:0]  ev_disable = '0;
  logic [N-1:0]  ev_drive = '0;
  logic [N-1:0]  amp_on, drive_en, settled, ready_ev;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  amp_settle_seq uut (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .timebase(timebase),
    .settle_time(settle_time), .always_on(always_on), .event_en(event_en),
    .out_normal(out_normal), .ev_enable(ev_enable), .ev_disable(ev_disable),
    .ev_drive(ev_drive), .amp_on(amp_on), .drive_en(drive_en),
    .settled(settled), .ready_ev(ready_ev)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_all();
    @(negedge clk);
    periph_en = 0; always_on = '0; event_en = '0; out_normal = '0;
    ev_enable = '0; ev_disable = '0; ev_drive = '0;
    @(negedge clk);
  endtask

  // counts edges from the current negedge until settled[idx] is seen
  task automatic wait_settle(input int idx, output int n, output bit rdy);
    n = 0; rdy = 0;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (settled[idx]) begin rdy = ready_ev[idx]; break; end
    end
  endtask

  task automatic t_reset();
    check(amp_on == 0,   "R4 reset amp_on", amp_on, 0);
    check(settled == 0,  "R3 reset settled", settled, 0);
    check(drive_en == 0, "R8 reset drive_en", drive_en, 0);
  endtask

  task automatic t_timing(input int idx, input int tb, input int s);
    int n; bit rdy; int exp;
    idle_all();
    timebase = 8'(tb);
    settle_time[idx*SW +: SW] = 7'(s);
    always_on[idx] = 1;
    periph_en = 1;
    if (s == 0) exp = 1;
    else if (tb == 0) exp = s + 1;
    else exp = s * (tb + 1);
    wait_settle(idx, n, rdy);
    check(n == exp, "R1 R2 settle edges", n, exp);
    check(rdy, "R3 ready with settled", rdy, 1);
    @(negedge clk);
    check(!ready_ev[idx], "R3 ready one cycle", ready_ev[idx], 0);
    check(settled[idx], "R3 settled holds", settled[idx], 1);
    periph_en = 0;
    #1;
    check(amp_on == 0, "R9 global off", amp_on, 0);
  endtask

  task automatic pulse(input logic [N-1:0] en, input logic [N-1:0] dis);
    @(negedge clk); ev_enable = en; ev_disable = dis;
    @(negedge clk); ev_enable = '0; ev_disable = '0;
  endtask

  task automatic t_events();
    idle_all();
    timebase = 0; periph_en = 1;
    pulse(3'b001, 3'b000);
    check(!amp_on[0], "R5 ignored without event_en", amp_on[0], 0);
    event_en[0] = 1;
    pulse(3'b001, 3'b000);
    check(amp_on[0], "R4 enable event", amp_on[0], 1);
    always_on[0] = 1;
    pulse(3'b000, 3'b001);
    check(amp_on[0], "R5 disable ignored under always_on", amp_on[0], 1);
    always_on[0] = 0;
    #1;
    check(amp_on[0], "R5 event state kept", amp_on[0], 1);
    pulse(3'b001, 3'b001);
    check(!amp_on[0], "R6 both from on", amp_on[0], 0);
    pulse(3'b001, 3'b001);
    check(!amp_on[0], "R6 both from off", amp_on[0], 0);
    check(amp_on[2:1] == 0, "R4 others untouched", amp_on[2:1], 0);
  endtask

  task automatic t_restart();
    int n; bit rdy;
    idle_all();
    timebase = 0; settle_time[1*SW +: SW] = 7'd2;
    event_en[1] = 1; periph_en = 1;
    pulse(3'b010, 3'b000);
    wait_settle(1, n, rdy);
    check(settled[1], "R7 first settle", settled[1], 1);
    @(negedge clk); ev_disable[1] = 1;
    @(posedge clk); #1;
    check(!amp_on[1] && !settled[1], "R7 off clears settled", settled[1], 0);
    @(negedge clk); ev_disable[1] = 0; ev_enable[1] = 1;
    @(posedge clk); @(negedge clk); ev_enable[1] = 0;
    n = 1;
    if (!settled[1]) begin
      wait_settle(1, n, rdy);
      n++;
    end
    check(n == 4, "R7 restart full countdown", n, 4);
    @(negedge clk); periph_en = 0;
    @(negedge clk); periph_en = 1;
    #1;
    check(!amp_on[1], "R9 events cleared", amp_on[1], 0);
  endtask

  task automatic t_drive();
    idle_all();
    timebase = 0; always_on[2] = 1; periph_en = 1;
    #1;
    check(!drive_en[2], "R8 off mode idle", drive_en[2], 0);
    ev_drive[2] = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(drive_en[2], "R8 drive level held", drive_en[2], 1);
    end
    ev_drive[2] = 0; #1;
    check(!drive_en[2], "R8 drive released", drive_en[2], 0);
    out_normal[2] = 1; #1;
    check(drive_en[2], "R8 normal mode", drive_en[2], 1);
    always_on[2] = 0; ev_drive[2] = 1; #1;
    check(!drive_en[2], "R8 off instance no drive", drive_en[2], 0);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timing(0, 2, 3);
    t_timing(1, 0, 5);
    t_timing(2, 0, 0);
    t_timing(0, 3, 1);
    t_events();
    t_restart();
    t_drive();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule